// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block decides, clock by clock, whether the core enters an exception, and it produces the machine state for the instruction that follows. Two causes are handled. The first is an asynchronous external interrupt request. The second is a synchronous alignment fault raised by the load or store currently being decoded. When a cause is accepted, the block saves the resume address and the low half of the machine state register into the two save/restore registers. It also rewrites the machine state register and issues a one-cycle redirect together with the address of the vector to fetch.

The block owns the machine state register. The core can load that register through a write port, which is how interrupts are enabled again after a handler. Bit positions in the state register use big-endian numbering: bit 0 is the most significant bit of the 32-bit word. The interrupt-enable field is bit 16, the interrupt-endian shadow is bit 15, the machine-check enable is bit 19, the vector-base select is bit 25 and the little-endian mode is bit 31. All positions are parameters.

Top module: `exc_entry_unit`

## Requirements
- R1: Every accepted exception leaves the interrupt-enable bit (big-endian bit 16, vector index 15) at 0 in the state register on the cycle the redirect is high.
- R2: An external interrupt is accepted only if `irq_req` is 1, the interrupt-enable bit is 1 and no alignment fault is present in the same cycle. In every other case it causes no redirect.
- R3: While `redirect_o` is high, `vector_o` equals the base plus the offset. The base is 0x00000000 when the old vector-base bit (big-endian bit 25) is 0, and 0xFFF00000 when it is 1. The offset is 0x500 for an external interrupt and 0x600 for an alignment fault.
- R4: On an accepted exception, `srr0_o` takes the value of `next_pc` from the accepting cycle.
- R5: On an accepted exception, `srr1_o` bits 15:0 (big-endian 16 to 31) take the old state bits 15:0, and `srr1_o` bits 31:16 become zero.
- R6: On an accepted exception, the new state has the little-endian bit (big-endian 31, index 0) equal to the old interrupt-endian shadow (big-endian 15, index 16). The machine-check enable (index 12) and the vector-base bit (index 6) keep their old values. Every other bit is 0.
- R7: An alignment fault is raised when `ls_valid` is 1, `ls_kind` is 1 (floating point), 2 (multiple word) or 3 (reserve/conditional), and `ls_addr[1:0]` is not 00. `ls_kind` 0 never faults, and the interrupt-enable bit has no effect on the fault.
- R8: When an alignment fault and an enabled interrupt arrive together, the alignment fault is taken with offset 0x600. The held interrupt is taken later, once the interrupt-enable bit is written back to 1.
- R9: After reset, the state register, `srr0_o` and `srr1_o` are all zero and `redirect_o` is 0.
- R10: When no exception is accepted, `msr_wr_en` loads `msr_wr_data` into the state register on the next edge. In a cycle where an exception is accepted, the write is ignored.
- R11: `redirect_o` is high only for the cycle after an accepting edge. Without an exception, the state register and the save/restore registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level external interrupt request |
| ls_valid | input | 1 | A load or store is being decoded |
| ls_kind | input | 2 | Access class: 0 other, 1 float, 2 multiple, 3 reserve/conditional |
| ls_addr | input | 32 | Effective operand address |
| next_pc | input | 32 | Address of the instruction that would run next |
| msr_wr_en | input | 1 | Load the state register |
| msr_wr_data | input | 32 | Value to load |
| msr_o | output | 32 | Current machine state register |
| srr0_o | output | 32 | Saved resume address |
| srr1_o | output | 32 | Saved state |
| redirect_o | output | 1 | One-cycle fetch redirect |
| vector_o | output | 32 | Vector fetch address, valid with redirect |

## Verification
The assertions assume that every input is at a known value from the first edge after reset. They also assume that `irq_req` is a level, held by its source until the handler clears it, so an interrupt that is held off is seen again after the enable bit returns. The bench drives all inputs with defined values on falling edges. It keeps `irq_req` as a level over stretches of several cycles and sets the enable bit again only through the write port, so both assumptions hold throughout the run.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      LS_OTHER = 2'd0,
      LS_FLOAT = 2'd1,
      LS_MULTI = 2'd2,
      LS_RESV  = 2'd3
   } ls_kind_e;

   typedef enum logic [1:0] {
      TAKE_NONE   = 2'd0,
      TAKE_ALIGN  = 2'd1,
      TAKE_EXTIRQ = 2'd2
   } take_e;

   function automatic int be_to_ix(input int width, input int be_pos);
      return width - 1 - be_pos;
   endfunction

endpackage

// File: rtl/exc_align_detect.sv
module exc_align_detect
   import exc_entry_pkg::*;
#(
   parameter int AW          = 32,
   parameter int ALIGN_BYTES = 4
) (
   input  logic          valid,
   input  logic [1:0]    kind,
   input  logic [AW-1:0] addr,
   output logic          fault
);
   localparam int LSB = $clog2(ALIGN_BYTES);

   generate
      if ((1 << LSB) != ALIGN_BYTES) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two");
      end
      if (LSB == 0) begin : g_no_check
         logic unused_in;
         assign unused_in = valid ^ (^kind) ^ (^addr);
         assign fault     = 1'b0;
      end else begin : g_check
         localparam logic [AW-1:0] LOW_MASK = AW'((1 << LSB) - 1);
         logic restricted;
         assign restricted = (ls_kind_e'(kind) != LS_OTHER);
         assign fault      = valid && restricted && ((addr & LOW_MASK) != '0);
      end
   endgenerate
endmodule

// File: rtl/exc_prio.sv
module exc_prio
   import exc_entry_pkg::*;
(
   input  logic  align_fault,
   input  logic  irq_req,
   input  logic  irq_enable,
   output take_e take
);
   always_comb begin
      if (align_fault)                take = TAKE_ALIGN;
      else if (irq_req && irq_enable) take = TAKE_EXTIRQ;
      else                            take = TAKE_NONE;
   end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ME_IX  = 12,
   parameter int IP_IX  = 6,
   parameter int LE_IX  = 0,
   parameter int ILE_IX = 16,
   parameter logic [XLEN-1:0] BASE_LO = '0,
   parameter logic [XLEN-1:0] BASE_HI = 32'hFFF0_0000,
   parameter logic [XLEN-1:0] VEC_EXT = 32'h0000_0500,
   parameter logic [XLEN-1:0] VEC_ALN = 32'h0000_0600
) (
   input  logic [XLEN-1:0] msr_cur,
   input  take_e           take,
   output logic [XLEN-1:0] msr_nxt,
   output logic [XLEN-1:0] srr1_nxt,
   output logic [XLEN-1:0] vec_nxt
);
   localparam int HALF = XLEN / 2;
   localparam logic [XLEN-1:0] LOW_MASK = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_msr_bit
         if (i == ME_IX || i == IP_IX) begin : g_keep
            assign msr_nxt[i] = msr_cur[i];
         end else if (i == LE_IX) begin : g_endian
            assign msr_nxt[i] = msr_cur[ILE_IX];
         end else begin : g_clear
            assign msr_nxt[i] = 1'b0;
         end
      end
   endgenerate

   assign srr1_nxt = msr_cur & LOW_MASK;

   logic [XLEN-1:0] base;
   assign base    = msr_cur[IP_IX] ? BASE_HI : BASE_LO;
   assign vec_nxt = base + ((take == TAKE_ALIGN) ? VEC_ALN : VEC_EXT);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int ALIGN_BYTES = 4,
   parameter int EE_BE       = 16,
   parameter int ILE_BE      = 15,
   parameter int ME_BE       = 19,
   parameter int IP_BE       = 25,
   parameter int LE_BE       = 31,
   parameter logic [XLEN-1:0] BASE_LO = '0,
   parameter logic [XLEN-1:0] BASE_HI = 32'hFFF0_0000,
   parameter logic [XLEN-1:0] VEC_EXT = 32'h0000_0500,
   parameter logic [XLEN-1:0] VEC_ALN = 32'h0000_0600
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic            ls_valid,
   input  logic [1:0]      ls_kind,
   input  logic [XLEN-1:0] ls_addr,
   input  logic [XLEN-1:0] next_pc,
   input  logic            msr_wr_en,
   input  logic [XLEN-1:0] msr_wr_data,
   output logic [XLEN-1:0] msr_o,
   output logic [XLEN-1:0] srr0_o,
   output logic [XLEN-1:0] srr1_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] vector_o
);
   localparam int EE_IX  = be_to_ix(XLEN, EE_BE);
   localparam int ILE_IX = be_to_ix(XLEN, ILE_BE);
   localparam int ME_IX  = be_to_ix(XLEN, ME_BE);
   localparam int IP_IX  = be_to_ix(XLEN, IP_BE);
   localparam int LE_IX  = be_to_ix(XLEN, LE_BE);

   generate
      if (XLEN % 2 != 0 || XLEN < 8) begin : g_bad_xlen
         $error("XLEN must be even and at least 8");
      end
      if (EE_BE >= XLEN || ILE_BE >= XLEN || ME_BE >= XLEN ||
          IP_BE >= XLEN || LE_BE >= XLEN) begin : g_bad_pos
         $error("state bit position outside XLEN");
      end
   endgenerate

   logic            align_fault;
   take_e           take;
   logic [XLEN-1:0] msr_q, srr0_q, srr1_q, vec_q;
   logic [XLEN-1:0] msr_nxt, srr1_nxt, vec_nxt;
   logic            redirect_q;

   exc_align_detect #(.AW(XLEN), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
      .valid (ls_valid),
      .kind  (ls_kind),
      .addr  (ls_addr),
      .fault (align_fault)
   );

   exc_prio u_prio (
      .align_fault (align_fault),
      .irq_req     (irq_req),
      .irq_enable  (msr_q[EE_IX]),
      .take        (take)
   );

   exc_state_calc #(
      .XLEN(XLEN), .ME_IX(ME_IX), .IP_IX(IP_IX), .LE_IX(LE_IX), .ILE_IX(ILE_IX),
      .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .VEC_EXT(VEC_EXT), .VEC_ALN(VEC_ALN)
   ) u_calc (
      .msr_cur  (msr_q),
      .take     (take),
      .msr_nxt  (msr_nxt),
      .srr1_nxt (srr1_nxt),
      .vec_nxt  (vec_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msr_q      <= '0;
         srr0_q     <= '0;
         srr1_q     <= '0;
         vec_q      <= '0;
         redirect_q <= 1'b0;
      end else if (take != TAKE_NONE) begin
         msr_q      <= msr_nxt;
         srr0_q     <= next_pc;
         srr1_q     <= srr1_nxt;
         vec_q      <= vec_nxt;
         redirect_q <= 1'b1;
      end else begin
         redirect_q <= 1'b0;
         if (msr_wr_en) msr_q <= msr_wr_data;
      end
   end

   assign msr_o      = msr_q;
   assign srr0_o     = srr0_q;
   assign srr1_o     = srr1_q;
   assign vector_o   = vec_q;
   assign redirect_o = redirect_q;
endmodule

// File: rtl/exc_entry_sva.sv
module exc_entry_sva #(
   parameter int XLEN = 32,
   parameter int EE_IX = 15,
   parameter int IP_IX = 6,
   parameter logic [XLEN-1:0] BASE_LO = '0,
   parameter logic [XLEN-1:0] BASE_HI = 32'hFFF0_0000,
   parameter logic [XLEN-1:0] VEC_EXT = 32'h0000_0500,
   parameter logic [XLEN-1:0] VEC_ALN = 32'h0000_0600
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            ls_valid,
   input logic [1:0]      ls_kind,
   input logic [XLEN-1:0] ls_addr,
   input logic [XLEN-1:0] next_pc,
   input logic            msr_wr_en,
   input logic [XLEN-1:0] msr_o,
   input logic [XLEN-1:0] srr0_o,
   input logic [XLEN-1:0] srr1_o,
   input logic            redirect_o,
   input logic [XLEN-1:0] vector_o
);
   localparam logic [XLEN-1:0] HIGH_MASK = {{(XLEN/2){1'b1}}, {(XLEN/2){1'b0}}};
   localparam logic [XLEN-1:0] WORD_MASK = XLEN'(3);

   logic afault, irq_ok;
   logic [XLEN-1:0] base_now;
   assign afault   = ls_valid && (ls_kind != 2'd0) && ((ls_addr & WORD_MASK) != '0);
   assign irq_ok   = irq_req && msr_o[EE_IX];
   assign base_now = msr_o[IP_IX] ? BASE_HI : BASE_LO;

   AST_EE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !msr_o[EE_IX]); // R1
   AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !msr_o[EE_IX] && !afault) |=> !redirect_o); // R2
   AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (vector_o == base_now + VEC_EXT || vector_o == base_now + VEC_ALN)); // R3
   AST_SRR0_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
      (afault || irq_ok) |=> (srr0_o == $past(next_pc))); // R4
   AST_SRR1_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> ((srr1_o & HIGH_MASK) == '0)); // R5
   AST_ALIGN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      afault |=> (redirect_o && vector_o == base_now + VEC_ALN)); // R8
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!afault && !irq_ok && !msr_wr_en) |=> (!redirect_o && $stable(msr_o) && $stable(srr0_o))); // R11
endmodule

bind exc_entry_unit exc_entry_sva #(
   .XLEN(XLEN), .EE_IX(EE_IX), .IP_IX(IP_IX),
   .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .VEC_EXT(VEC_EXT), .VEC_ALN(VEC_ALN)
) chk_i (.*);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, ls_valid = 1'b0, msr_wr_en = 1'b0;
   logic [1:0]  ls_kind = 2'd0;
   logic [31:0] ls_addr = '0, next_pc = '0, msr_wr_data = '0;
   logic [31:0] msr_o, srr0_o, srr1_o, vector_o;
   logic        redirect_o;

   int compared = 0;
   int mismatched = 0;

   // reference state
   logic [31:0] m_msr = '0, m_srr0 = '0, m_srr1 = '0, m_vec = '0;
   logic        m_red = 1'b0;

   always #10 clk = ~clk;

   exc_entry_unit dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ls_valid(ls_valid),
      .ls_kind(ls_kind), .ls_addr(ls_addr), .next_pc(next_pc),
      .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
      .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
      .redirect_o(redirect_o), .vector_o(vector_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural model of one edge; indices: EE 15, ILE 16, ME 12, IP 6, LE 0.
   task automatic model_edge();
      logic fault, take;
      logic [31:0] nm;
      fault = ls_valid && ls_kind != 2'd0 && ls_addr[1:0] != 2'b00;   // R7
      take  = fault || (irq_req && m_msr[15]);                         // R2 R8
      if (take) begin
         m_srr0 = next_pc;                                             // R4
         m_srr1 = {16'h0, m_msr[15:0]};                                // R5
         nm = 32'h0;
         nm[12] = m_msr[12];
         nm[6]  = m_msr[6];
         nm[0]  = m_msr[16];                                           // R6
         m_vec  = (m_msr[6] ? 32'hFFF0_0000 : 32'h0) + (fault ? 32'h600 : 32'h500); // R3
         m_msr  = nm;
         m_red  = 1'b1;
      end else begin
         m_red = 1'b0;                                                 // R11
         if (msr_wr_en) m_msr = msr_wr_data;                           // R10
      end
   endtask

   task automatic compare_all();
      chk("R6 msr", msr_o, m_msr);
      chk("R4 srr0", srr0_o, m_srr0);
      chk("R5 srr1", srr1_o, m_srr1);
      chk("R11 redirect", {31'h0, redirect_o}, {31'h0, m_red});
      if (m_red) chk("R3 vector", vector_o, m_vec);
   endtask

   // Called at a falling edge with inputs already set.
   task automatic step();
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      irq_req = 0; ls_valid = 0; ls_kind = 0; ls_addr = 0; msr_wr_en = 0;
   endtask

   task automatic write_msr(input logic [31:0] v);
      idle(); msr_wr_en = 1; msr_wr_data = v; step(); msr_wr_en = 0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      chk("R9 msr", msr_o, 32'h0);
      chk("R9 srr0", srr0_o, 32'h0);
      chk("R9 srr1", srr1_o, 32'h0);
      chk("R9 redirect", {31'h0, redirect_o}, 32'h0);

      // R2: interrupt with EE=0 ignored
      idle(); irq_req = 1; next_pc = 32'h100; step(); step();
      chk("R2 no redirect", {31'h0, redirect_o}, 32'h0);

      // R10: load enable; EE, ILE, ME, IP plus extra bits
      write_msr(32'h0001_9A5B);
      chk("R10 msr load", msr_o, 32'h0001_9A5B);

      // R1 R3 R6: interrupt taken, IP=1 high base
      idle(); irq_req = 1; next_pc = 32'h0000_2468; step();
      chk("R1 ee cleared", {31'h0, msr_o[15]}, 32'h0);
      chk("R3 ext vector", vector_o, 32'hFFF0_0500);
      chk("R6 le from ile", {31'h0, msr_o[0]}, 32'h1);
      irq_req = 0; step();
      chk("R11 single pulse", {31'h0, redirect_o}, 32'h0);

      // R7: kind 0 misaligned never faults; aligned float does not fault
      idle(); ls_valid = 1; ls_kind = 2'd0; ls_addr = 32'h3; step();
      chk("R7 other kind", {31'h0, redirect_o}, 32'h0);
      ls_kind = 2'd1; ls_addr = 32'h40; step();
      chk("R7 aligned", {31'h0, redirect_o}, 32'h0);
      // R7: each restricted kind faults even with EE=0
      for (int k = 1; k < 4; k++) begin
         idle(); ls_valid = 1; ls_kind = 2'(k); ls_addr = 32'h1000 + 32'(k); next_pc = 32'h700 + 32'(k);
         step();
         chk("R7 fault kind", {31'h0, redirect_o}, 32'h1);
      end

      // R8: simultaneous: align wins, irq later after EE set
      write_msr(32'h0000_8000);
      idle(); irq_req = 1; ls_valid = 1; ls_kind = 2'd3; ls_addr = 32'h2; next_pc = 32'h880; step();
      chk("R8 align vector", vector_o, 32'h0000_0600);
      ls_valid = 0; step();
      chk("R8 held while masked", {31'h0, redirect_o}, 32'h0);
      irq_req = 1; msr_wr_en = 1; msr_wr_data = 32'h0000_8000; step();
      msr_wr_en = 0; step();
      chk("R8 later irq", vector_o, 32'h0000_0500);

      // R10: write ignored in exception cycle
      write_msr(32'h0000_8000);
      idle(); irq_req = 1; msr_wr_en = 1; msr_wr_data = 32'hFFFF_FFFF; step();
      chk("R10 write dropped", msr_o, 32'h0);

      // random traffic compared every clock
      for (int n = 0; n < 4000; n++) begin
         idle();
         if ((n % 8) == 0) irq_req = $urandom_range(0, 1) == 1;
         ls_valid  = $urandom_range(0, 3) == 0;
         ls_kind   = 2'($urandom_range(0, 3));
         ls_addr   = $urandom;
         next_pc   = $urandom;
         msr_wr_en = $urandom_range(0, 5) == 0;
         msr_wr_data = $urandom;
         step();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule